// File: doc/BRIEF.md
# Flash Page Buffer Load Controller

This block runs the load half of a page-program operation on a parallel flash device. Once a program command has been armed, it accepts byte-load write cycles into a 128-byte page buffer. The cycles are timed by an active-low write strobe. The byte address is taken when the strobe falls and the data when it rises. Bytes may arrive in any order. The bank-select pin acts as the top bit of the byte position, so it picks the upper or lower 64-byte half of the page. The other address bits above the in-half offset name the page.

The first byte that is loaded locks the page. A write that names another page is dropped and raises an error flag. A strobe that falls too long after the previous rise is still accepted, but it raises a late flag. When the strobe stays high for the idle timeout, the load window closes. The block then runs a programming countdown. During that countdown it streams the whole page, one byte per cycle, through a write port to the array. Positions that were never loaded go out as FFh. At the end of the countdown a sticky completion flag is set, which serves as status bit 7.

Top module: `flash_page_loader`

## Requirements
- R1: After reset, busy, done, error and late flags are 0, all valid flags are 0, every buffer byte reads FFh and no array write is issued.
- R2: A byte's position is {bank, addr[5:0]}, with bank as bit 6, and its page is addr[19:6]. The position is taken in the cycle the strobe is first seen low. The data is taken in the cycle the strobe is first seen high again.
- R3: Bytes may be loaded in any order. Loading a position twice keeps the later value, and that position counts once in the valid flags.
- R4: An arm pulse in the idle state opens the window and resets the buffer to FFh with no valid flags. Positions not loaded stay FFh and are programmed as FFh.
- R5: The first loaded byte locks the page. A later byte in the same window whose page differs is discarded and sets the error flag.
- R6: Busy rises LOAD_TMO clock edges after the edge that registered the last accepted strobe rise (or the arm), provided the strobe stays high throughout.
- R7: Busy lasts PROG_CYCLES cycles. In its first 128 cycles, one array write per cycle goes out in ascending byte position, with address {page, position} and the buffered byte as data.
- R8: Done is set in the cycle busy falls and stays set until the next arm. An arm clears done, error and late.
- R9: A strobe fall that comes at least GAP_MAX high cycles after the previous accepted rise, once a byte is loaded, sets the late flag, and that byte is still stored.
- R10: A window that closes with no byte loaded sets done without entering programming.
- R11: Strobe cycles outside the load window, and arm pulses while loading or programming, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Program command armed pulse |
| wr_n_i | input | 1 | Active-low write strobe, synchronous |
| addr_i | input | ADDR_W | Byte address; upper bits select page |
| bank_i | input | 1 | Upper/lower half select, byte position bit 6 |
| data_i | input | 8 | Load data |
| buf_data_o | output | 8*128 | Page buffer contents, byte k at bits 8k+7:8k |
| buf_valid_o | output | 128 | Per-position loaded flags |
| busy_o | output | 1 | Programming countdown running |
| done_o | output | 1 | Completion flag (status bit 7) |
| err_o | output | 1 | Wrong-page write seen in window |
| late_o | output | 1 | Late byte seen in window |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W+1 | Array byte address {page, position} |
| arr_data_o | output | 8 | Array write data |

## Verification
A byte's value and valid flag become visible one edge after the cycle in which the rising strobe is seen. The error and late flags follow one edge after the falling strobe. Busy rises LOAD_TMO edges after the accepted rise, the array write port follows busy in the same cycle, and done rises on the edge where busy falls. A behavioural model in the bench advances on the same edges from the same sampled inputs, and every output is compared on the opposite clock edge, so each result is checked in exactly the cycle it is due.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ld_state_e;

  localparam int unsigned DEF_ADDR_W = 20;
  localparam int unsigned DEF_HALF_W = 6;
endpackage

// File: rtl/fpl_strobe_edge.sv
module fpl_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n_i,
  output logic fall_o,
  output logic rise_o
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n_i;
  end

  assign fall_o = wr_q & ~wr_n_i;
  assign rise_o = ~wr_q & wr_n_i;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_o && rise_o)); // R2
endmodule

// File: rtl/fpl_idle_timer.sv
module fpl_idle_timer #(
  parameter int unsigned LOAD_TMO = 10000,
  parameter int unsigned GAP_MAX  = 3000,
  localparam int unsigned CNT_W   = $clog2(LOAD_TMO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic expire_o,
  output logic late_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt <= '0;
    else if (restart_i)                          cnt <= '0;
    else if (run_i && cnt != CNT_W'(LOAD_TMO-1)) cnt <= cnt + 1'b1;
  end

  assign expire_o = run_i && (cnt == CNT_W'(LOAD_TMO-1));
  assign late_o   = (cnt >= CNT_W'(GAP_MAX));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LOAD_TMO-1)); // R6
endmodule

// File: rtl/fpl_page_store.sv
module fpl_page_store #(
  parameter int unsigned BYTES = 128,
  localparam int unsigned OFF_W = $clog2(BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [OFF_W-1:0]   woff_i,
  input  logic [7:0]         wdata_i,
  input  logic [OFF_W-1:0]   roff_i,
  output logic [8*BYTES-1:0] data_o,
  output logic [BYTES-1:0]   valid_o,
  output logic [7:0]         rdata_o
);
  for (genvar k = 0; k < BYTES; k++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_o[8*k +: 8] <= 8'hFF;
        valid_o[k]       <= 1'b0;
      end else if (clr_i) begin
        data_o[8*k +: 8] <= 8'hFF;
        valid_o[k]       <= 1'b0;
      end else if (we_i && woff_i == OFF_W'(k)) begin
        data_o[8*k +: 8] <= wdata_i;
        valid_o[k]       <= 1'b1;
      end
    end
  end

  assign rdata_o = data_o[8*roff_i +: 8];

  AST_VALID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> $countones(valid_o) <= $countones($past(valid_o)) + 1); // R3
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> valid_o == '0); // R4
endmodule

// File: rtl/flash_page_loader.sv
module flash_page_loader
  import fpl_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned HALF_W      = DEF_HALF_W,
  parameter int unsigned LOAD_TMO    = 10000,
  parameter int unsigned GAP_MAX     = 3000,
  parameter int unsigned PROG_CYCLES = 2000,
  localparam int unsigned OFF_W      = HALF_W + 1,
  localparam int unsigned PAGE_BYTES = 1 << OFF_W,
  localparam int unsigned PAGE_W     = ADDR_W - HALF_W,
  localparam int unsigned PCNT_W     = $clog2(PROG_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm_i,
  input  logic                    wr_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    bank_i,
  input  logic [7:0]              data_i,
  output logic [8*PAGE_BYTES-1:0] buf_data_o,
  output logic [PAGE_BYTES-1:0]   buf_valid_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic                    late_o,
  output logic                    arr_we_o,
  output logic [ADDR_W:0]         arr_addr_o,
  output logic [7:0]              arr_data_o
);
  function automatic logic [OFF_W-1:0] pos_in_page(input logic bank,
                                                   input logic [ADDR_W-1:0] a);
    return {bank, a[HALF_W-1:0]};
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:HALF_W];
  endfunction

  ld_state_e         state;
  logic              fall_ev, rise_ev, accept_rise;
  logic              fall_seen, discard_q, any_q;
  logic [OFF_W-1:0]  off_q;
  logic [PAGE_W-1:0] page_q;
  logic [PCNT_W-1:0] prog_cnt;
  logic              done_q, err_q, late_q;
  logic              arm_ev, tmo_ev, gap_late, store_we;
  logic [7:0]        rd_byte;

  fpl_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .wr_n_i(wr_n_i), .fall_o(fall_ev), .rise_o(rise_ev)
  );

  assign arm_ev      = (state == ST_IDLE) && arm_i;
  assign accept_rise = (state == ST_LOAD) && rise_ev && fall_seen;
  assign store_we    = accept_rise && !discard_q;

  fpl_idle_timer #(.LOAD_TMO(LOAD_TMO), .GAP_MAX(GAP_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .restart_i(arm_ev || accept_rise),
    .run_i((state == ST_LOAD) && wr_n_i && !accept_rise),
    .expire_o(tmo_ev), .late_o(gap_late)
  );

  fpl_page_store #(.BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_i(arm_ev),
    .we_i(store_we), .woff_i(off_q), .wdata_i(data_i),
    .roff_i(prog_cnt[OFF_W-1:0]),
    .data_o(buf_data_o), .valid_o(buf_valid_o), .rdata_o(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fall_seen <= 1'b0;
      discard_q <= 1'b0;
      any_q     <= 1'b0;
      off_q     <= '0;
      page_q    <= '0;
      prog_cnt  <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      late_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (arm_i) begin
          state     <= ST_LOAD;
          fall_seen <= 1'b0;
          discard_q <= 1'b0;
          any_q     <= 1'b0;
          done_q    <= 1'b0;
          err_q     <= 1'b0;
          late_q    <= 1'b0;
        end
        ST_LOAD: begin
          if (fall_ev) begin
            off_q     <= pos_in_page(bank_i, addr_i);
            fall_seen <= 1'b1;
            if (any_q && page_of(addr_i) != page_q) begin
              discard_q <= 1'b1;
              err_q     <= 1'b1;
            end else begin
              discard_q <= 1'b0;
              if (!any_q) page_q <= page_of(addr_i);
            end
            if (any_q && gap_late) late_q <= 1'b1;
          end
          if (accept_rise) begin
            fall_seen <= 1'b0;
            if (!discard_q) any_q <= 1'b1;
          end
          if (tmo_ev) begin
            if (any_q) begin
              state    <= ST_PROG;
              prog_cnt <= '0;
            end else begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (prog_cnt == PCNT_W'(PROG_CYCLES-1)) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            prog_cnt <= prog_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state == ST_PROG);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign late_o     = late_q;
  assign arr_we_o   = busy_o && (int'(prog_cnt) < PAGE_BYTES);
  assign arr_addr_o = {page_q, prog_cnt[OFF_W-1:0]};
  assign arr_data_o = rd_byte;

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o); // R8
  AST_DONE_AT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R8
  AST_WE_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o); // R7
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(page_q)); // R7
  AST_ERR_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(fall_ev) && $past(any_q)); // R5
  AST_LATE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_q) |-> $past(any_q) && $past(fall_ev)); // R9
endmodule

// File: tb/flash_page_loader_tb.sv
`timescale 1ns/1ps
module flash_page_loader_tb;
  localparam int TMO = 200, GAP = 60, PCY = 300, NB = 128;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, wr_n = 1'b1, bank = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0]  data = '0;
  logic [8*NB-1:0] buf_data;
  logic [NB-1:0]   buf_valid;
  logic busy, done, err, late, awe;
  logic [20:0] aaddr;
  logic [7:0]  adata;

  int vecs = 0, miss = 0;

  always #5 clk = ~clk;

  flash_page_loader #(.LOAD_TMO(TMO), .GAP_MAX(GAP), .PROG_CYCLES(PCY)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .wr_n_i(wr_n), .addr_i(addr),
    .bank_i(bank), .data_i(data), .buf_data_o(buf_data), .buf_valid_o(buf_valid),
    .busy_o(busy), .done_o(done), .err_o(err), .late_o(late),
    .arr_we_o(awe), .arr_addr_o(aaddr), .arr_data_o(adata)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st, m_cnt, m_pc, m_off, m_page, pg;
  bit m_wq, m_any, m_fseen, m_disc, m_done, m_err, m_late, m_fall, m_rise;
  int m_buf[NB];
  bit m_val[NB];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_wq = 1; m_any = 0; m_fseen = 0; m_disc = 0; m_done = 0;
      m_err = 0; m_late = 0; m_cnt = 0; m_pc = 0; m_off = 0; m_page = 0;
      foreach (m_buf[i]) begin m_buf[i] = 255; m_val[i] = 0; end
    end else begin
      m_fall = m_wq && !wr_n;
      m_rise = !m_wq && wr_n;
      m_wq = wr_n;
      if (m_st == 0) begin
        if (arm) begin
          m_st = 1; m_any = 0; m_fseen = 0; m_disc = 0; m_cnt = 0;
          m_done = 0; m_err = 0; m_late = 0;
          foreach (m_buf[i]) begin m_buf[i] = 255; m_val[i] = 0; end
        end
      end else if (m_st == 1) begin
        if (m_fall) begin
          m_off = bank * 64 + addr % 64;
          pg = addr / 64;
          m_fseen = 1;
          if (m_any && m_cnt >= GAP) m_late = 1;
          if (m_any && pg != m_page) begin m_disc = 1; m_err = 1; end
          else begin m_disc = 0; if (!m_any) m_page = pg; end
        end else if (m_rise && m_fseen) begin
          m_fseen = 0; m_cnt = 0;
          if (!m_disc) begin m_buf[m_off] = data; m_val[m_off] = 1; m_any = 1; end
        end else if (wr_n) begin
          if (m_cnt == TMO - 1) begin
            if (m_any) begin m_st = 2; m_pc = 0; end
            else begin m_st = 0; m_done = 1; end
          end else m_cnt++;
        end
      end else begin
        if (m_pc == PCY - 1) begin m_st = 0; m_done = 1; end
        else m_pc++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NB-1:0] ev;
      int bad;
      bad = -1;
      for (int i = 0; i < NB; i++) begin
        ev[i] = m_val[i];
        if (bad < 0 && buf_data[8*i +: 8] != m_buf[i][7:0]) bad = i;
      end
      chk(busy == (m_st == 2), "R6 busy", busy, m_st == 2);
      chk(buf_valid == ev, "R3 valid", buf_valid[63:0], ev[63:0]);
      chk(bad < 0, "R4 buffer byte", bad < 0 ? 0 : buf_data[8*bad +: 8],
          bad < 0 ? 0 : m_buf[bad]);
      chk(done == m_done, "R8 done", done, m_done);
      chk(err == m_err, "R5 err", err, m_err);
      chk(late == m_late, "R9 late", late, m_late);
      chk(awe == (m_st == 2 && m_pc < NB), "R7 array we", awe, m_st == 2 && m_pc < NB);
      if (m_st == 2 && m_pc < NB) begin
        chk(aaddr == 21'(m_page * NB + m_pc), "R7 array addr", aaddr, m_page * NB + m_pc);
        chk(adata == m_buf[m_pc][7:0], "R7 array data", adata, m_buf[m_pc]);
      end
    end
  end

  task automatic load_byte(input int page, input bit bk, input int a, input int d, input int gap);
    @(negedge clk);
    wr_n = 0; addr = 20'(page * 64 + a); bank = bk; data = 8'(~d);
    repeat (2) @(negedge clk);
    wr_n = 1; data = 8'(d);
    repeat (1 + gap) @(negedge clk);
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !late && !awe, "R1 flags", {busy, done, err, late, awe}, 0);
    chk(buf_valid == '0, "R1 valid", buf_valid[63:0], 0);
    chk(buf_data == '1, "R1 buffer", buf_data[63:0], 64'hFFFF_FFFF_FFFF_FFFF);

    // any order, both halves, overwrite, capture edges
    pulse_arm();
    load_byte(12'h1A3, 0, 5, 8'h11, 3);
    load_byte(12'h1A3, 1, 2, 8'h22, 3);
    load_byte(12'h1A3, 0, 0, 8'h33, 3);
    load_byte(12'h1A3, 0, 5, 8'h44, 3);
    chk(buf_data[8*66 +: 8] == 8'h22 && buf_valid[66], "R2 bank is bit 6", buf_data[8*66 +: 8], 8'h22);
    chk(buf_data[8*5 +: 8] == 8'h44, "R3 overwrite keeps later", buf_data[8*5 +: 8], 8'h44);
    chk($countones(buf_valid) == 3, "R3 counted once", $countones(buf_valid), 3);
    wait_done();
    chk(done && !busy, "R8 done after program", done, 1);

    // wrong page discarded
    pulse_arm();
    chk(!done, "R8 arm clears done", done, 0);
    load_byte(12'h0F0, 1, 7, 8'h5A, 3);
    load_byte(12'h0F1, 0, 9, 8'hA5, 3);
    chk(err && $countones(buf_valid) == 1, "R5 discard", $countones(buf_valid), 1);
    wait_done();

    // late byte still stored
    pulse_arm();
    chk(!err, "R8 arm clears err", err, 0);
    load_byte(12'h002, 0, 1, 8'h01, 70);
    load_byte(12'h002, 0, 2, 8'h02, 3);
    chk(late && buf_valid[2], "R9 late accepted", late, 1);
    wait_done();

    // empty window
    pulse_arm();
    wait_done();
    chk(done && buf_valid == '0, "R10 empty window", done, 1);

    // strobes outside window, arm during program
    load_byte(12'h3FF, 1, 63, 8'h77, 3);
    chk(buf_valid == '0 && done && !busy, "R11 idle strobe ignored", buf_valid[63:0], 0);
    pulse_arm();
    load_byte(12'h011, 1, 0, 8'h9C, 3);
    for (int i = 0; i < 400 && !busy; i++) @(negedge clk);
    pulse_arm();
    chk(busy && !done, "R11 arm in program ignored", busy, 1);
    wait_done();
    chk(done && buf_data[8*64 +: 8] == 8'h9C, "R11 program completes", buf_data[8*64 +: 8], 8'h9C);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule